// File: doc/BRIEF.md
# Three-Channel DMA Grant Arbiter with Selectable Priority Order

This block picks which of three DMA channels may use the shared transfer path. Each channel raises a request line. The arbiter answers with a one-hot grant. It holds that grant until the granted channel reports that its burst or single transfer has finished. Only then does it arbitrate again.

A small global control register holds a master enable and a 2-bit order field. The order field selects one of four fixed priority orderings, and that ordering resolves simultaneous requests. After reset the ordering puts channel 1 first rather than channel 0, and the master enable is off. Software writes the register through a simple write strobe and reads it back on a dedicated output.

Top module: `dma_order_arbiter`

## Requirements
- R1: While and directly after reset, `gnt` is 3'b000 and `cfg_rdata` is 3'b000, which means order field 00 and enable off.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_wdata` is stored in the control register. `cfg_rdata` shows the stored value from that edge on. Bit 0 is the master enable and bits 2:1 are the order field.
- R3: While the stored enable bit is 0, no new grant is issued, whatever requests are present.
- R4: With order field 11, simultaneous requests are resolved channel 0 first, then channel 1, then channel 2.
- R5: With order field 10, simultaneous requests are resolved channel 2 first, then channel 1, then channel 0.
- R6: With order field 01, simultaneous requests are resolved channel 1 first, then channel 0, then channel 2.
- R7: With order field 00, simultaneous requests are resolved channel 1 first, then channel 2, then channel 0.
- R8: `gnt` is one-hot or zero. When the arbiter is enabled, holds no grant and sees at least one request at a clock edge, exactly one requesting channel is granted from that edge on (bit n of `gnt` is channel n).
- R9: A grant stays unchanged until `ch_done` is 1 on the bit of the granted channel. A `ch_done` bit of a channel that is not granted, and a drop of the requests, have no effect on `gnt`.
- R10: At the edge where the granted channel's `ch_done` bit is 1, `gnt` returns to zero. The next arbitration happens at the following edge.
- R11: Writing a new order field or clearing the enable while a grant is held leaves that grant in place. The new order field governs the next decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 3 | Control value: bit 0 enable, bits 2:1 order field |
| cfg_rdata | output | 3 | Current control register value |
| req | input | 3 | Request line per channel |
| ch_done | input | 3 | End-of-transfer pulse per channel |
| gnt | output | 3 | One-hot grant, zero when idle |

## Verification
The assertions check the grant's shape and timing on every cycle: the grant is one-hot, it is held until the owner's done, it drops right after that done, an idle enabled arbiter that sees a request issues a grant, a new grant always goes to a channel that was requesting, and no grant starts while the block is disabled. The assertions do not check which requester wins. Only the bench scenarios show that, by running each of the four order values against chosen request patterns. The scenarios also show that a mode change written during a held grant waits for the next decision, and that the register reads back after reset and after each write.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int NCH    = 3;
  localparam int MODE_W = 2;
  localparam int CFG_W  = MODE_W + 1;
  localparam int IDX_W  = $clog2(NCH);

  typedef logic [NCH-1:0]    chan_vec_t;
  typedef logic [MODE_W-1:0] order_sel_t;
  typedef logic [IDX_W-1:0]  chan_idx_t;

  typedef struct packed {
    order_sel_t order;
    logic       enable;
  } arb_cfg_t;

  // Channel that sits at position 'rank' (0 = highest) for a given order code.
  function automatic chan_idx_t rank_to_chan(input order_sel_t sel, input int rank);
    chan_idx_t ch;
    unique case (sel)
      2'b11: ch = chan_idx_t'(rank);                        // 0,1,2
      2'b10: ch = chan_idx_t'(NCH - 1 - rank);              // 2,1,0
      2'b01: ch = (rank == 0) ? chan_idx_t'(1) :
                  (rank == 1) ? chan_idx_t'(0) : chan_idx_t'(2); // 1,0,2
      default: ch = (rank == 0) ? chan_idx_t'(1) :
                    (rank == 1) ? chan_idx_t'(2) : chan_idx_t'(0); // 1,2,0
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_val,
  output arb_cfg_t         cfg
);

  arb_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= arb_cfg_t'(wr_val);
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
  import dma_arb_pkg::*;
(
  input  order_sel_t sel,
  input  chan_vec_t  req,
  output chan_vec_t  pick
);

  always_comb begin
    logic      found;
    chan_idx_t ch;
    pick  = '0;
    found = 1'b0;
    for (int r = 0; r < NCH; r++) begin
      ch = rank_to_chan(sel, r);
      if (!found && req[ch]) begin
        pick[ch] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold
  import dma_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  chan_vec_t req,
  input  chan_vec_t pick,
  input  chan_vec_t done,
  output chan_vec_t gnt,
  output logic      start_ev,
  output logic      release_ev
);

  chan_vec_t gnt_q;
  logic      idle;

  assign idle       = (gnt_q == '0);
  assign release_ev = |(gnt_q & done);
  assign start_ev   = idle && enable && (|req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else if (release_ev) begin
      gnt_q <= '0;
    end else if (start_ev) begin
      gnt_q <= pick;
    end
  end

  assign gnt = gnt_q;

endmodule

// File: rtl/dma_order_arbiter.sv
module dma_order_arbiter
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [NCH-1:0]   req,
  input  logic [NCH-1:0]   ch_done,
  output logic [NCH-1:0]   gnt
);

  arb_cfg_t  cfg;
  chan_vec_t pick;
  chan_vec_t gnt_w;
  logic      start_ev;
  logic      release_ev;

  arb_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_val (cfg_wdata),
    .cfg    (cfg)
  );

  arb_prio_pick u_pick (
    .sel  (cfg.order),
    .req  (req),
    .pick (pick)
  );

  arb_grant_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg.enable),
    .req        (req),
    .pick       (pick),
    .done       (ch_done),
    .gnt        (gnt_w),
    .start_ev   (start_ev),
    .release_ev (release_ev)
  );

  assign gnt       = gnt_w;
  assign cfg_rdata = CFG_W'(cfg);

endmodule

// File: rtl/dma_order_arbiter_chk.sv
module dma_order_arbiter_chk
  import dma_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req,
  input logic [NCH-1:0]   ch_done,
  input logic [NCH-1:0]   gnt,
  input logic [CFG_W-1:0] cfg_rdata
);

  logic en_now;
  assign en_now = cfg_rdata[0];

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r8_idle_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (en_now && gnt == '0 && |req) |=> (gnt != '0));

  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (gnt == '0 || (gnt & $past(req)) != '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & ch_done) == '0) |=> $stable(gnt));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ch_done) != '0) |=> (gnt == '0));

  a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_now && gnt == '0) |=> (gnt == '0));

endmodule

bind dma_order_arbiter dma_order_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .ch_done   (ch_done),
  .gnt       (gnt),
  .cfg_rdata (cfg_rdata)
);

// File: tb/dma_order_arbiter_tb.sv
module dma_order_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic [2:0] req = '0;
  logic [2:0] ch_done = '0;
  logic [2:0] gnt;

  always #2.5 clk = ~clk;   // 200 MHz

  dma_order_arbiter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req       (req),
    .ch_done   (ch_done),
    .gnt       (gnt)
  );

  typedef struct {
    int         due;
    logic [2:0] gnt;
    logic [2:0] cfg;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic [2:0] cfg_model = '0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares expectations that fall due in this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (gnt !== e.gnt) begin
        n_fail++;
        $display("FAIL %s gnt actual=%b expected=%b", e.tag, gnt, e.gnt);
      end
      n_chk++;
      if (cfg_rdata !== e.cfg) begin
        n_fail++;
        $display("FAIL R2 (%s) cfg_rdata actual=%b expected=%b", e.tag, cfg_rdata, e.cfg);
      end
    end
  end

  // Driver: one cycle of stimulus plus the grant expected after that edge
  task automatic step(input logic [2:0] r, input logic [2:0] d, input bit we,
                      input logic [2:0] wv, input logic [2:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; ch_done = d; cfg_we = we; cfg_wdata = wv;
    if (we) cfg_model = wv;
    e.due = cyc + 1; e.gnt = eg; e.cfg = cfg_model; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (gnt !== 3'b000 || cfg_rdata !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset gnt=%b cfg=%b expected 000/000", gnt, cfg_rdata);
    end
    rst_n = 1'b1;
    step(3'b111, 3'b000, 0, 3'b000, 3'b000, "R1 after reset");
    step(3'b111, 3'b000, 0, 3'b000, 3'b000, "R3 disabled");
    step(3'b111, 3'b000, 1, 3'b001, 3'b000, "R2 write en mode00");
    step(3'b111, 3'b000, 0, 3'b000, 3'b010, "R7 mode00 all req");
    step(3'b111, 3'b001, 0, 3'b000, 3'b010, "R9 foreign done");
    step(3'b000, 3'b000, 0, 3'b000, 3'b010, "R9 req dropped");
    step(3'b000, 3'b000, 1, 3'b111, 3'b010, "R11 mode write held");
    step(3'b111, 3'b010, 0, 3'b000, 3'b000, "R10 release");
    step(3'b111, 3'b000, 0, 3'b000, 3'b001, "R4 mode11 all req");
    step(3'b000, 3'b001, 0, 3'b000, 3'b000, "R10 release");
    step(3'b110, 3'b000, 0, 3'b000, 3'b010, "R4 mode11 req 110");
    step(3'b000, 3'b010, 0, 3'b000, 3'b000, "R10 release");
    step(3'b000, 3'b000, 1, 3'b101, 3'b000, "R2 write mode10");
    step(3'b011, 3'b000, 0, 3'b000, 3'b010, "R5 mode10 req 011");
    step(3'b000, 3'b010, 0, 3'b000, 3'b000, "R10 release");
    step(3'b111, 3'b000, 0, 3'b000, 3'b100, "R5 mode10 all req");
    step(3'b000, 3'b100, 0, 3'b000, 3'b000, "R10 release");
    step(3'b000, 3'b000, 1, 3'b011, 3'b000, "R2 write mode01");
    step(3'b101, 3'b000, 0, 3'b000, 3'b001, "R6 mode01 req 101");
    step(3'b000, 3'b001, 0, 3'b000, 3'b000, "R10 release");
    step(3'b111, 3'b000, 0, 3'b000, 3'b010, "R6 mode01 all req");
    step(3'b000, 3'b010, 0, 3'b000, 3'b000, "R10 release");
    step(3'b000, 3'b000, 1, 3'b001, 3'b000, "R2 write mode00");
    step(3'b101, 3'b000, 0, 3'b000, 3'b100, "R7 mode00 req 101");
    step(3'b101, 3'b100, 0, 3'b000, 3'b000, "R10 release with req");
    step(3'b101, 3'b000, 0, 3'b000, 3'b100, "R8 rearbitrate");
    step(3'b101, 3'b000, 1, 3'b000, 3'b100, "R11 disable held");
    step(3'b101, 3'b100, 0, 3'b000, 3'b000, "R10 release");
    step(3'b101, 3'b000, 0, 3'b000, 3'b000, "R3 disabled req");
    step(3'b111, 3'b111, 0, 3'b000, 3'b000, "R3 disabled done");
    step(3'b000, 3'b000, 0, 3'b000, 3'b000, "R3 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule